// File: doc/BRIEF.md
# Reconfiguration page select controller

This block sits inside a board controller and is reached through a small host register bus. Four byte-wide registers sit behind it. One is a write-only trigger that asks for the main FPGA to be reloaded. One is an override bit. One is a software page number. One is a read-only copy of a two-bit board jumper.

When the trigger register receives the value zero, the block takes a flash page number. That number comes from the software register when the override is clear, and from the synchronized jumper when it is set. The block then raises a one-cycle reload request and drives the page number on a separate output. The page output stays fixed until the downstream loader reports that it has finished. Any trigger that arrives before that is dropped.

Register writes take effect at the clock edge that samples them. No separate commit step exists.

Top module: `reload_page_ctrl`

## Requirements
- R1: A write of 0x00 to offset 0 while no reload is pending makes `reload_req` high for exactly one cycle, in the cycle after the write edge. A nonzero write to offset 0 produces no request.
- R2: The page latched on `reload_page` at a trigger comes from one of two sources. When the override bit is 0, it is the software page register. When the override bit is 1, it is the synchronized jumper value, zero-extended to the page width. The register values used are those held before the trigger edge.
- R3: While a reload is pending, `reload_page` stays stable and further zero writes to offset 0 produce no request. A one-cycle `reload_done` ends the pending state, and the next zero write is accepted.
- R4: A read of offset 0 returns 0x00.
- R5: Offset 1 holds the override bit in bit 0. Reads return it with all other bits zero.
- R6: Offset 2 holds the software page, 0 to 7. A write keeps only write-data bits 2:0, and a read returns the page with bits 7:3 zero.
- R7: Offset 3 returns the synchronized jumper in bits 1:0, where 1 means user image and 2 means factory image. Writes to offset 3 change nothing.
- R8: The jumper passes through two flops. A change applied before clock edge k is seen by reads sampled at edge k+2 or later. Reads sampled at edges k and k+1 still return the old value.
- R9: After reset, the override bit and the software page are 0, `reload_req` is 0, `reload_page` is 0 and `reg_rdata` is 0.
- R10: Read data is registered. It is valid in the cycle after the edge that samples `reg_rd` high, and it is 0x00 in any cycle that follows an edge with no read. A read in the cycle after a write returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| jumper_in | input | 2 | Asynchronous board jumper value |
| reload_done | input | 1 | Loader finished the pending reload |
| reload_req | output | 1 | One-cycle reload request pulse |
| reload_page | output | 3 | Flash page for the reload |

## Verification
Every result shows up one register stage after the edge that samples its cause. Read data and the reload pulse both appear in the cycle after their strobe. The jumper adds two further edges before reads can see it.

The bench drives inputs on the falling edge and samples outputs on the next falling edge, half a cycle after the result is due. For the synchronizer, it issues three back-to-back reads straight after a jumper change and expects old, old, new. For the pulse width, it checks one falling edge later that the request has already dropped.

// File: rtl/reload_page_ctrl.sv
module reload_page_ctrl #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3,
  parameter int JMP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [JMP_W-1:0]  jumper_in,
  input  logic              reload_done,
  output logic              reload_req,
  output logic [PAGE_W-1:0] reload_page
);
  localparam logic [1:0] OFS_TRIG = 2'd0;
  localparam logic [1:0] OFS_OVR  = 2'd1;
  localparam logic [1:0] OFS_SW   = 2'd2;
  localparam logic [1:0] OFS_JMP  = 2'd3;

  logic [JMP_W-1:0]  jmp_meta, jmp_sync;
  logic              ovr;
  logic [PAGE_W-1:0] sw_page;
  logic              pending;
  logic [DATA_W-1:0] rd_mux;

  wire trig = reg_wr && (reg_addr == OFS_TRIG) && (reg_wdata == '0) && !pending;
  wire [PAGE_W-1:0] jmp_page = PAGE_W'(jmp_sync);
  wire [PAGE_W-1:0] sel_page = ovr ? jmp_page : sw_page;

  always_comb begin
    case (reg_addr)
      OFS_OVR: rd_mux = DATA_W'(ovr);
      OFS_SW:  rd_mux = DATA_W'(sw_page);
      OFS_JMP: rd_mux = DATA_W'(jmp_sync);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jmp_meta    <= '0;
      jmp_sync    <= '0;
      ovr         <= 1'b0;
      sw_page     <= '0;
      pending     <= 1'b0;
      reload_req  <= 1'b0;
      reload_page <= '0;
      reg_rdata   <= '0;
    end else begin
      jmp_meta   <= jumper_in;
      jmp_sync   <= jmp_meta;
      reload_req <= trig;
      reg_rdata  <= reg_rd ? rd_mux : '0;
      if (reg_wr && reg_addr == OFS_OVR) ovr     <= reg_wdata[0];
      if (reg_wr && reg_addr == OFS_SW)  sw_page <= reg_wdata[PAGE_W-1:0];
      if (trig) begin
        reload_page <= sel_page;
        pending     <= 1'b1;
      end else if (reload_done) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

module reload_page_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              reload_done,
  input logic              reload_req,
  input logic [PAGE_W-1:0] reload_page,
  input logic              pending,
  input logic              ovr
);
  assert_req_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> !reload_req);

  assert_page_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !reload_done) |=> ($stable(reload_page) && !reload_req));

  assert_trig_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0) |=> (reg_rdata == '0));

  assert_ovr_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> (ovr == $past(reg_wdata[0])));

  assert_sw_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2) |=> (reg_rdata[DATA_W-1:PAGE_W] == '0));

  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == '0));
endmodule

bind reload_page_ctrl reload_page_ctrl_chk #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reload_done(reload_done),
  .reload_req(reload_req), .reload_page(reload_page), .pending(pending), .ovr(ovr)
);

// File: tb/reload_page_ctrl_test.sv
module reload_page_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] jumper_in = 2'd2;
  logic       reload_done = 1'b0;
  logic       reload_req;
  logic [2:0] reload_page;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  reload_page_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .jumper_in(jumper_in),
    .reload_done(reload_done), .reload_req(reload_req), .reload_page(reload_page)
  );

  // {addr, wdata, expected readback}
  localparam logic [17:0] VEC [8] = '{
    {2'd1, 8'h01, 8'h01},  // R5
    {2'd1, 8'hFE, 8'h00},  // R5
    {2'd2, 8'h05, 8'h05},  // R6
    {2'd2, 8'h0F, 8'h07},  // R6
    {2'd2, 8'hF8, 8'h00},  // R6
    {2'd3, 8'h03, 8'h01},  // R7 (jumper = user)
    {2'd0, 8'h55, 8'h00},  // R4
    {2'd2, 8'h03, 8'h03}   // R10
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic done_pulse();
    reload_done = 1'b1;
    @(posedge clk); @(negedge clk);
    reload_done = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reload_req", {7'd0, reload_req}, 8'h00);
    chk("R9 reload_page", {5'd0, reload_page}, 8'h00);
    chk("R9 rdata", reg_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, rv); chk("R9 override", rv, 8'h00);
    rd(2'd2, rv); chk("R9 sw page", rv, 8'h00);
    @(negedge clk);
    chk("R10 idle rdata", reg_rdata, 8'h00);

    jumper_in = 2'd1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][17:16], VEC[i][15:8]);
      rd(VEC[i][17:16], rv);
      chk("R4-7 vector readback", rv, VEC[i][7:0]);
    end
    chk("R1 nonzero write no request", {7'd0, reload_req}, 8'h00);

    // R1 / R2: software source
    wr(2'd0, 8'h00);
    chk("R1 pulse high", {7'd0, reload_req}, 8'h01);
    chk("R2 software page", {5'd0, reload_page}, 8'h03);
    @(negedge clk);
    chk("R1 pulse one cycle", {7'd0, reload_req}, 8'h00);

    // R3: ignored while pending
    wr(2'd2, 8'h06);
    wr(2'd0, 8'h00);
    chk("R3 no retrigger", {7'd0, reload_req}, 8'h00);
    chk("R3 page held", {5'd0, reload_page}, 8'h03);
    done_pulse();
    wr(2'd0, 8'h00);
    chk("R3 accepted after done", {7'd0, reload_req}, 8'h01);
    chk("R3 new page", {5'd0, reload_page}, 8'h06);
    done_pulse();

    // R8: synchronizer latency, then R2 jumper source
    jumper_in = 2'd2;
    rd(2'd3, rv); chk("R8 edge k old", rv, 8'h01);
    rd(2'd3, rv); chk("R8 edge k+1 old", rv, 8'h01);
    rd(2'd3, rv); chk("R8 edge k+2 new", rv, 8'h02);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h00);
    chk("R2 jumper page", {5'd0, reload_page}, 8'h02);
    chk("R2 jumper pulse", {7'd0, reload_req}, 8'h01);
    done_pulse();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule